// File: doc/BRIEF.md
# Masking Generator Reseed Scheduler

This block decides when the pseudo-random generator that produces masking values has to be reseeded, and whether that generator may step forward on a given cycle. It counts completed cipher blocks against a selectable interval: every block, every 64 blocks or every 8192 blocks. It also raises a reseed request on an explicit software trigger. A key update raises one too, when the option for that is switched on.

A single request line stays high until the entropy side acknowledges it. Any further causes that arrive in the meantime fold into that one request. While a request is open, the cipher engine is expected to stall, so no block runs on stale masks. Block-done pulses seen during that time are neither counted nor allowed to advance the generator.

A debug setting freezes the masks by holding the advance enable low. A sticky lock makes the key-change option, the freeze setting and the lock itself read-only until reset. The interval field stays writable even when the lock is set.

Top module: `mask_reseed_sched`

## Requirements
- R1: After reset the request output is low, the interval select is 3'b001 (every block), the key-change option and the freeze setting are off, the lock is clear and the block count is zero.
- R2: The interval select is one-hot and takes effect when `cfgWrite` is high. 3'b001 requests after every accepted block, 3'b010 after every 64th and 3'b100 after every 8192nd. The request rises in the cycle after the block-done pulse that completes the interval.
- R3: Any interval select value that is not one of the three one-hot codes behaves as 3'b001.
- R4: A `keyChange` pulse raises the request in the next cycle only while the registered key-change option is on. When the option is off, the pulse has no effect.
- R5: A `reseedTrig` pulse raises the request in the next cycle, at any time and under any configuration.
- R6: The request stays high until `reseedAck` is seen. Triggers, key changes and block pulses that arrive while it is high merge into it, so one acknowledge clears all of them.
- R7: An acknowledge while the request is high clears the request and resets the block count to zero in the next cycle. If a trigger or an enabled key change arrives in that same cycle, the request stays high.
- R8: While the request is high, block-done pulses are not counted and `prngAdvanceEn` stays low.
- R9: `prngAdvanceEn` is high in the same cycle as `blockDone` only when no request is open and masks are not frozen.
- R10: Once the lock is set, configuration writes leave the key-change option, the freeze setting and the lock unchanged until reset. Interval writes still take effect.
- R11: An acknowledge while no request is open has no effect; in particular, the partial block count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| blockDone | input | 1 | One-cycle pulse per finished cipher block |
| keyChange | input | 1 | One-cycle pulse when the key is updated |
| reseedTrig | input | 1 | Software reseed trigger pulse |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgInterval | input | 3 | One-hot interval select written on `cfgWrite` |
| cfgKeyReseed | input | 1 | Key-change reseed option written on `cfgWrite` |
| cfgFreeze | input | 1 | Mask-freeze setting written on `cfgWrite` |
| cfgLock | input | 1 | Lock bit written on `cfgWrite` |
| reseedAck | input | 1 | Reseed completed acknowledge |
| reseedReq | output | 1 | Reseed request; also the stall condition for the cipher |
| prngAdvanceEn | output | 1 | Permits the masking generator to step this cycle |

## Verification
The acknowledge that closes a request can fall in the same cycle as a new cause: a software trigger, an enabled key change, or a block pulse arriving while the request is still open. The bench drives such coincident pulses on purpose. For each one it decides from its own model whether the request must drop or stay high, and whether the count restarts from zero. It also writes the lock bit together with new freeze and key-change values in a single write, to confirm that the lock only governs later writes.

// File: rtl/mask_reseed_pkg.sv
package mask_reseed_pkg;

  localparam logic [2:0] SEL_EVERY = 3'b001;
  localparam logic [2:0] SEL_MID   = 3'b010;
  localparam logic [2:0] SEL_LONG  = 3'b100;

  // strobes issued by the control to the count/request datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic reqSet;
    logic reqClr;
  } strobe_t;

endpackage

// File: rtl/mask_reseed_ctrl.sv
module mask_reseed_ctrl
  import mask_reseed_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       blockDone,
  input  logic       keyChange,
  input  logic       reseedTrig,
  input  logic       cfgWrite,
  input  logic [2:0] cfgInterval,
  input  logic       cfgKeyReseed,
  input  logic       cfgFreeze,
  input  logic       cfgLock,
  input  logic       reseedAck,
  input  logic       pendingQ,
  input  logic       termHit,
  output strobe_t    strobe,
  output logic [2:0] intervalQ,
  output logic       keyReseedQ,
  output logic       freezeQ,
  output logic       lockQ,
  output logic       prngAdvanceEn
);

  logic acceptBlock;
  logic ackLive;
  logic keyEvent;

  // configuration; lock guards the option bits and itself
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalQ  <= SEL_EVERY;
      keyReseedQ <= 1'b0;
      freezeQ    <= 1'b0;
      lockQ      <= 1'b0;
    end else if (cfgWrite) begin
      intervalQ <= cfgInterval;
      if (!lockQ) begin
        keyReseedQ <= cfgKeyReseed;
        freezeQ    <= cfgFreeze;
        lockQ      <= cfgLock;
      end
    end
  end

  always_comb begin
    acceptBlock   = blockDone && !pendingQ;
    ackLive       = reseedAck && pendingQ;
    keyEvent      = keyChange && keyReseedQ;
    strobe.cntInc = acceptBlock;
    strobe.cntClr = ackLive;
    strobe.reqSet = reseedTrig || keyEvent || (acceptBlock && termHit);
    strobe.reqClr = ackLive;
    prngAdvanceEn = acceptBlock && !freezeQ;
  end

endmodule

// File: rtl/mask_reseed_dp.sv
module mask_reseed_dp
  import mask_reseed_pkg::*;
#(
  parameter int MID_BLOCKS  = 64,
  parameter int LONG_BLOCKS = 8192
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobe,
  input  logic [2:0] intervalSel,
  output logic       pendingQ,
  output logic       termHit
);

  localparam int CNT_W = $clog2(LONG_BLOCKS + 1);
  localparam logic [CNT_W:0] LIM_ONE  = (CNT_W+1)'(1);
  localparam logic [CNT_W:0] LIM_MID  = (CNT_W+1)'(MID_BLOCKS);
  localparam logic [CNT_W:0] LIM_LONG = (CNT_W+1)'(LONG_BLOCKS);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W:0]   limit;
  logic [CNT_W:0]   countNext;

  always_comb begin
    case (intervalSel)
      SEL_MID:  limit = LIM_MID;
      SEL_LONG: limit = LIM_LONG;
      default:  limit = LIM_ONE;
    endcase
    countNext = {1'b0, countQ} + (CNT_W+1)'(1);
    termHit   = countNext >= limit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.cntClr) begin
      countQ <= '0;
    end else if (strobe.cntInc && !termHit) begin
      countQ <= countNext[CNT_W-1:0];
    end else if (strobe.cntInc) begin
      countQ <= countQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (strobe.reqSet) begin
      pendingQ <= 1'b1;
    end else if (strobe.reqClr) begin
      pendingQ <= 1'b0;
    end
  end

endmodule

// File: rtl/mask_reseed_sched.sv
module mask_reseed_sched
  import mask_reseed_pkg::*;
#(
  parameter int MID_BLOCKS  = 64,
  parameter int LONG_BLOCKS = 8192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       blockDone,
  input  logic       keyChange,
  input  logic       reseedTrig,
  input  logic       cfgWrite,
  input  logic [2:0] cfgInterval,
  input  logic       cfgKeyReseed,
  input  logic       cfgFreeze,
  input  logic       cfgLock,
  input  logic       reseedAck,
  output logic       reseedReq,
  output logic       prngAdvanceEn
);

  strobe_t    strobe;
  logic [2:0] intervalQ;
  logic       keyReseedQ;
  logic       freezeQ;
  logic       lockQ;
  logic       pendingQ;
  logic       termHit;

  mask_reseed_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .blockDone(blockDone), .keyChange(keyChange),
    .reseedTrig(reseedTrig), .cfgWrite(cfgWrite), .cfgInterval(cfgInterval),
    .cfgKeyReseed(cfgKeyReseed), .cfgFreeze(cfgFreeze), .cfgLock(cfgLock),
    .reseedAck(reseedAck), .pendingQ(pendingQ), .termHit(termHit),
    .strobe(strobe), .intervalQ(intervalQ), .keyReseedQ(keyReseedQ),
    .freezeQ(freezeQ), .lockQ(lockQ), .prngAdvanceEn(prngAdvanceEn)
  );

  mask_reseed_dp #(.MID_BLOCKS(MID_BLOCKS), .LONG_BLOCKS(LONG_BLOCKS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intervalSel(intervalQ),
    .pendingQ(pendingQ), .termHit(termHit)
  );

  assign reseedReq = pendingQ;

endmodule

// File: rtl/mask_reseed_chk.sv
module mask_reseed_chk (
  input logic clk,
  input logic rstN,
  input logic blockDone,
  input logic reseedTrig,
  input logic reseedAck,
  input logic reseedReq,
  input logic prngAdvanceEn,
  input logic freezeQ,
  input logic lockQ
);

  assert_trig_raises_R5: assert property (@(posedge clk) disable iff (!rstN)
    reseedTrig |=> reseedReq);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reseedReq && !reseedAck) |=> reseedReq);

  assert_no_adv_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    reseedReq |-> !prngAdvanceEn);

  assert_adv_needs_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    prngAdvanceEn |-> (blockDone && !freezeQ));

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

endmodule

bind mask_reseed_sched mask_reseed_chk chk_i (
  .clk(clk), .rstN(rstN), .blockDone(blockDone), .reseedTrig(reseedTrig),
  .reseedAck(reseedAck), .reseedReq(reseedReq), .prngAdvanceEn(prngAdvanceEn),
  .freezeQ(freezeQ), .lockQ(lockQ)
);

// File: tb/mask_reseed_sched_tb_top.sv
`timescale 1ns/1ps
module mask_reseed_sched_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blockDone = 0, keyChange = 0, reseedTrig = 0, cfgWrite = 0;
  logic [2:0] cfgInterval = 3'b001;
  logic cfgKeyReseed = 0, cfgFreeze = 0, cfgLock = 0, reseedAck = 0;
  logic reseedReq, prngAdvanceEn;

  always #2 clk = ~clk;

  mask_reseed_sched dut_i (
    .clk(clk), .rstN(rstN), .blockDone(blockDone), .keyChange(keyChange),
    .reseedTrig(reseedTrig), .cfgWrite(cfgWrite), .cfgInterval(cfgInterval),
    .cfgKeyReseed(cfgKeyReseed), .cfgFreeze(cfgFreeze), .cfgLock(cfgLock),
    .reseedAck(reseedAck), .reseedReq(reseedReq), .prngAdvanceEn(prngAdvanceEn)
  );

  int errors = 0;
  int checks = 0;
  string curReq = "R1";
  bit finished = 0;

  // behavioural reference state
  int   mCount = 0;
  bit   mPend = 0, mKeyEn = 0, mFreeze = 0, mLock = 0;
  logic [2:0] mSel = 3'b001;

  function automatic int limitOf(logic [2:0] s);
    if (s == 3'b010) return 64;
    if (s == 3'b100) return 8192;
    return 1;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // inputs are already driven; compare, clock the model, drop pulses
  task automatic step();
    bit accept, ackLive, ev;
    #1;
    check(curReq, reseedReq, mPend, "reseedReq");
    check(curReq, prngAdvanceEn, blockDone && !mPend && !mFreeze, "prngAdvanceEn");
    accept  = blockDone && !mPend;
    ackLive = reseedAck && mPend;
    ev = reseedTrig || (keyChange && mKeyEn) ||
         (accept && (mCount + 1 >= limitOf(mSel)));
    @(posedge clk);
    if (ackLive) mCount = 0;
    else if (accept && mCount + 1 < limitOf(mSel)) mCount++;
    mPend = ev ? 1'b1 : (ackLive ? 1'b0 : mPend);
    if (cfgWrite) begin
      mSel = cfgInterval;
      if (!mLock) begin
        mKeyEn = cfgKeyReseed; mFreeze = cfgFreeze; mLock = cfgLock;
      end
    end
    @(negedge clk);
    blockDone = 0; keyChange = 0; reseedTrig = 0; reseedAck = 0; cfgWrite = 0;
  endtask

  task automatic writeCfg(logic [2:0] sel, bit ke, bit fr, bit lk);
    cfgWrite = 1; cfgInterval = sel; cfgKeyReseed = ke; cfgFreeze = fr; cfgLock = lk;
    step();
  endtask

  task automatic blocks(int n);
    for (int i = 0; i < n; i++) begin blockDone = 1; step(); end
  endtask

  task automatic ack();
    reseedAck = 1; step();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    curReq = "R1";
    step(); step();
    // R1: after reset an ungated block goes through at interval 1
    blocks(1);
    check("R1", reseedReq, 1, "default every-block interval");
    ack();

    curReq = "R2";
    blocks(3);
    ack();
    writeCfg(3'b010, 0, 0, 0);
    blocks(63);
    check("R2", reseedReq, 0, "no request before 64th block");
    blocks(1);
    check("R2", reseedReq, 1, "request after 64th block");
    curReq = "R8";
    blocks(5);
    ack();
    curReq = "R2";
    blocks(64);
    check("R2", reseedReq, 1, "64 more after ack (R8 pulses not counted)");
    ack();
    writeCfg(3'b100, 0, 0, 0);
    blocks(8191);
    check("R2", reseedReq, 0, "none before 8192nd");
    blocks(1);
    check("R2", reseedReq, 1, "request after 8192nd");
    ack();

    curReq = "R3";
    writeCfg(3'b011, 0, 0, 0);
    blocks(1);
    check("R3", reseedReq, 1, "invalid select 011 acts as every block");
    ack();
    writeCfg(3'b000, 0, 0, 0);
    blocks(2);
    ack();

    curReq = "R4";
    keyChange = 1; step();
    check("R4", reseedReq, 0, "key change ignored while option off");
    writeCfg(3'b010, 1, 0, 0);
    keyChange = 1; step();
    check("R4", reseedReq, 1, "key change requests while option on");
    ack();

    curReq = "R5";
    reseedTrig = 1; step();
    check("R5", reseedReq, 1, "trigger requests");
    curReq = "R6";
    reseedTrig = 1; step();
    keyChange = 1; blockDone = 1; step();
    step();
    ack();
    check("R6", reseedReq, 0, "single ack clears merged events");

    curReq = "R7";
    reseedTrig = 1; step();
    reseedAck = 1; reseedTrig = 1; step();
    check("R7", reseedReq, 1, "trigger with ack keeps request");
    reseedAck = 1; keyChange = 1; step();
    check("R7", reseedReq, 1, "key change with ack keeps request");
    ack();
    check("R7", reseedReq, 0, "plain ack clears");

    curReq = "R11";
    blocks(10);
    ack();
    blocks(53);
    check("R11", reseedReq, 0, "count kept across stray ack");
    blocks(1);
    check("R11", reseedReq, 1, "request at 64 counting pre-ack blocks");
    ack();

    curReq = "R9";
    writeCfg(3'b010, 1, 1, 0);
    blocks(3);
    writeCfg(3'b010, 1, 0, 0);
    blocks(2);

    curReq = "R10";
    writeCfg(3'b010, 0, 1, 1);
    writeCfg(3'b001, 1, 0, 0);
    blocks(1);
    check("R10", prngAdvanceEn, 0, "freeze kept under lock");
    check("R10", reseedReq, 1, "interval writable under lock");
    ack();
    keyChange = 1; step();
    check("R10", reseedReq, 0, "key option stayed off under lock");
    step();

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule